// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles, reusing a single adder/subtractor. A one-cycle start request, accepted only while the block is idle, captures a multiplicand and a multiplier. The multiplier is placed in the low half of a double-width accumulator and the high half is cleared. One extra bit holds the bit that was last shifted out.

Each busy cycle looks at a bit pair: the lowest accumulator bit, as the current bit, and the saved bit, as the previous one. On pair 10 the multiplicand is subtracted from the high half. On pair 01 it is added. On pairs 00 and 11 nothing is added. The whole accumulator then shifts right by one place, copying the sign bit in. After WIDTH such cycles a one-cycle done pulse marks the signed product, which is shown as a high word and a low word. Because the shift keeps the sign, signed operands need no complementing before or after the multiply.

The adder is one bit wider than an operand. A multiplicand equal to the most negative value therefore cannot flip the sign of a partial sum.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is asserted, busy_o and done_o are 0 and both product halves read 0.
- R2: A start_i high at a clock edge while busy_o is 0 captures both operands, and busy_o reads 1 after that edge.
- R3: done_o rises exactly WIDTH clock edges after the edge that accepted start, stays high for one cycle only, and is never high together with busy_o.
- R4: When done_o is high, {prod_hi_o, prod_lo_o} equals the signed product of mcand_i and mplier_i as captured at start, with prod_hi_o as the upper WIDTH bits.
- R5: Each iteration chooses its action from the pair (current bit, previous bit). Pair 10 subtracts the multiplicand from the high half, pair 01 adds it, and pairs 00 and 11 add nothing. The accumulator then shifts right one place with sign extension, and the previous bit starts at 0.
- R6: An operand equal to the most negative value, as multiplicand, as multiplier or as both, still gives the correct signed product.
- R7: A start_i seen while busy_o is 1 is ignored: it changes neither the result of the running operation nor the time at which done_o rises.
- R8: While idle, with no start, the product outputs hold their last value.
- R9: busy_o stays high for exactly WIDTH consecutive cycles per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, taken only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| prod_hi_o | output | WIDTH | Upper half of the signed product |
| prod_lo_o | output | WIDTH | Lower half of the signed product |

## Verification
The multiplier runs at a 4-bit width, so all 256 signed operand pairs are tried and every sequence of bit pairs occurs. Known vectors cover the following cases:
- 2 times 7, whose long run of ones ends in one add.
- 2 times -3, whose pairs alternate between subtract and add.
- Zero operands, where nothing is ever added.
- Most-negative operands, which expose a sign lost in a narrow adder.

Directed tests cover a start request raised mid-run, the product holding while idle, and reset applied during an operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Action chosen for one Booth iteration
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);

  // R5: pair (current, previous) selects the action
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b10:   op_o = OP_SUB;
      2'b01:   op_o = OP_ADD;
      default: op_o = OP_SKIP;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_op_e        op_i,
  output logic [WIDTH:0]   sum_o
);

  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] hi_ext;
  logic [EXT_W-1:0] mc_ext;

  // One guard bit keeps the true sign of the partial sum (R6)
  assign hi_ext = {hi_i[WIDTH-1], hi_i};
  assign mc_ext = {mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  sum_o = hi_ext + mc_ext;
      OP_SUB:  sum_o = hi_ext - mc_ext;
      default: sum_o = hi_ext;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (!busy_q && start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign load_o = !busy_q && start_i;
  assign step_o = busy_q;

  // Checker counter: busy cycles since the last accepted start
  logic [31:0] chk_busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_busy_len <= '0;
    else if (load_o) chk_busy_len <= '0;
    else if (busy_q) chk_busy_len <= chk_busy_len + 1;
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy_q));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q && chk_busy_len == 32'(WIDTH)));

  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && cnt_q != LAST) |=> busy_q);

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] prod_hi_o,
  output logic [WIDTH-1:0] prod_lo_o
);

  logic rst_sync_n;
  logic load, step;

  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [WIDTH-1:0] hi_q, hi_d;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic             prev_q, prev_d;

  booth_op_e        op;
  logic [WIDTH:0]   sum;

  booth_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step)
  );

  booth_recode u_recode (
    .cur_i  (lo_q[0]),
    .prev_i (prev_q),
    .op_o   (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .hi_i    (hi_q),
    .mcand_i (mcand_q),
    .op_i    (op),
    .sum_o   (sum)
  );

  // Next-state of the product / multiplier register
  always_comb begin
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    prev_d  = prev_q;
    if (load) begin
      mcand_d = mcand_i;
      hi_d    = '0;
      lo_d    = mplier_i;
      prev_d  = 1'b0;
    end else if (step) begin
      // Arithmetic right shift of {sum, lo, prev}
      hi_d   = sum[WIDTH:1];
      lo_d   = {sum[0], lo_q[WIDTH-1:1]};
      prev_d = lo_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      prev_q  <= 1'b0;
    end else if (load || step) begin
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      prev_q  <= prev_d;
    end
  end

  assign prod_hi_o = hi_q;
  assign prod_lo_o = lo_q;

  p_mcand_held_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |=> $stable(mcand_q));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !start_i) |=> ($stable(hi_q) && $stable(lo_q)));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |=> (hi_q == '0 && !prev_q));

  p_skip_shift_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && (lo_q[0] == prev_q)) |=> (hi_q[WIDTH-1] == $past(hi_q[WIDTH-1])));

endmodule

// File: tb/booth_mul_seq_bench.sv
`timescale 1ns/1ps
module booth_mul_seq_bench;

  localparam int W = 4;
  localparam int NV = 9;

  // {multiplicand, multiplier, expected product}
  localparam logic [4*W-1:0] VEC [NV] = '{
    16'h270E,  // 2 * 7
    16'h2DFA,  // 2 * -3
    16'h8840,  // -8 * -8
    16'h87C8,  // -8 * 7
    16'h78C8,  // 7 * -8
    16'hFF01,  // -1 * -1
    16'h0500,  // 0 * 5
    16'h5000,  // 5 * 0
    16'h81F8   // -8 * 1
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [W-1:0] mcand, mplier;
  logic busy, done;
  logic [W-1:0] phi, plo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) u_booth_mul_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .busy_o    (busy),
    .done_o    (done),
    .prod_hi_o (phi),
    .prod_lo_o (plo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start one multiply; return the product and the cycles until done
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke_mid,
                         output logic [2*W-1:0] prod, output int cyc);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check("R2 busy after start", 32'(busy), 32'd1);
    while (!done && cyc < 100) begin
      if (poke_mid && cyc == 2) begin
        start = 1'b1; mcand = ~a; mplier = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    prod = {phi, plo};
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] p;
    int cyc;
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplier = '0;
    #1;
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 product in reset", 32'({phi, plo}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table of vectors (R4, R5, R6)
    for (int i = 0; i < NV; i++) begin
      run_mul(VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W], 1'b0, p, cyc);
      check("R4 R5 R6 vector product", 32'(p), 32'(VEC[i][2*W-1:0]));
      check("R3 done latency", 32'(cyc), 32'(W + 1));
    end

    // Sweep of all operand pairs (R4, R6)
    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
        int e;
        e = a * b;
        run_mul(W'(a), W'(b), 1'b0, p, cyc);
        check("R4 sweep product", 32'(p), 32'(e[2*W-1:0]));
      end
    end

    // Start while busy is ignored (R7); busy length (R9)
    run_mul(4'd2, 4'd7, 1'b1, p, cyc);
    check("R7 start while busy ignored, product", 32'(p), 32'h0E);
    check("R7 R9 done timing unchanged", 32'(cyc), 32'(W + 1));
    @(negedge clk);
    check("R3 done one cycle only", 32'(done), 32'd0);
    check("R9 busy low after done", 32'(busy), 32'd0);

    // Hold while idle (R8)
    mcand = 4'h5; mplier = 4'h3;
    repeat (4) @(negedge clk);
    check("R8 product held while idle", 32'({phi, plo}), 32'h0E);

    // Reset during operation (R1)
    @(negedge clk);
    start = 1'b1; mcand = 4'h3; mplier = 4'h5;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 busy cleared by reset", 32'(busy), 32'd0);
    check("R1 product cleared by reset", 32'({phi, plo}), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_mul(4'hD, 4'hD, 1'b0, p, cyc);
    check("R4 product after reset recovery", 32'(p), 32'h09);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule